// File: doc/BRIEF.md
# DRAM Clock-Enable Power-State Tracker

This block follows the low-power condition of a DDR SDRAM device as a memory controller drives it. On every clock edge it takes three things. The first is the clock-enable level on that edge. The second is the level it kept from the edge before. The third is the command decoded on the same edge. It also looks at a flag that tells whether any bank is open. From these it decides whether the device stays in, enters or leaves precharge power-down, active power-down or self refresh. Any state, enable pair and command that has no defined meaning is flagged as illegal.

The outputs are registered. After each edge they show four things: the new power state, a one-cycle action code for what that edge did, an illegal-sequence flag, and a read-permitted flag. Leaving self refresh starts a relock window of a set number of cycles. In that window reads are refused, which stands in for the time the device's delay-locked loop needs to lock again. Once the enable is high on two edges in a row, the state simply follows the bank-open flag.

Top module: `cke_power_tracker`

## Requirements
- R1: After reset, powerState is 0 (idle), actionCode is 0, illegalSeq is 0 and readOk is 1. The remembered enable level is low. The state codes are: 0 idle, 1 bank active, 2 precharge power-down, 3 active power-down, 4 self refresh.
- R2: In self refresh (4), an edge with the enable low now and on the previous edge keeps state 4 with actionCode 1 (hold). The command is ignored.
- R3: In self refresh, enable low then high with command 0 (NOP or deselect) moves to idle (0) with actionCode 6. Any other command on that edge gives actionCode 7 with illegalSeq 1, and the state stays 4.
- R4: In either power-down state, two low enable samples keep the state with actionCode 1. Low then high with NOP gives actionCode 5 and returns to 0 from state 2, or to 1 from state 3. Any other command on that edge is illegal, and the state does not change.
- R5: In a normal state (0 or 1), enable high then low with NOP and no bank open enters state 2 with actionCode 2.
- R6: In a normal state, enable high then low with command 1 (auto refresh) and no bank open enters state 4 with actionCode 3.
- R7: In a normal state, enable high then low with NOP and a bank open enters state 3 with actionCode 4.
- R8: In a normal state, enable high on both edges gives actionCode 0. The state becomes 1 if a bank is open and 0 if none is. Low then high with NOP (enable bring-up) acts the same way.
- R9: Counting the self-refresh exit edge as edge 0, a read (command 2) on edges 1 to RELOCK_CYCLES-1 is illegal and the state is unchanged. A read from edge RELOCK_CYCLES on gives actionCode 0. readOk is 0 during the window and in every low-power state.
- R10: Each self-refresh exit restarts the relock window from zero, even when the previous window had not yet ended.
- R11: Every other combination is illegal: actionCode 7, illegalSeq 1 and the state held. Examples are a read or command 3 on a falling enable, auto refresh with a bank open, a high previous sample in a low-power state, and two low samples in a normal state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ckeIn | input | 1 | Clock-enable level on this edge |
| cmdIn | input | 2 | Decoded command: 0 NOP/deselect, 1 auto refresh, 2 read, 3 other |
| anyBankOpen | input | 1 | High when at least one bank is open |
| powerState | output | 3 | Current power state code |
| actionCode | output | 3 | Action of the last edge: 0 none, 1 hold, 2 enter precharge PD, 3 enter self refresh, 4 enter active PD, 5 exit PD, 6 exit self refresh, 7 illegal |
| illegalSeq | output | 1 | High for the edge that saw an undefined sequence |
| readOk | output | 1 | High when a read on the next edge would be accepted |

## Verification
Two functions can fall on the same cycle: the relock window and the normal-state decode. When a read arrives during the window with the enable high on both edges, an ordinary command edge has to become an illegal one. This case is provoked twice. The first read comes one edge after an exit. The second comes 150 edges after a second exit, and that exit follows a self-refresh entry made while the first window was still running. Each read is judged by whether illegalSeq rises and the state holds, and by a later read at exactly the window length giving actionCode 0.

// File: rtl/cke_tracker_pkg.sv
package cke_tracker_pkg;

  typedef enum logic [2:0] {
    PS_IDLE     = 3'd0,
    PS_ACTIVE   = 3'd1,
    PS_PRE_PD   = 3'd2,
    PS_ACT_PD   = 3'd3,
    PS_SELF_REF = 3'd4
  } pwrState_t;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_AREF  = 2'd1,
    CMD_READ  = 2'd2,
    CMD_OTHER = 2'd3
  } cmd_t;

  typedef enum logic [2:0] {
    ACT_NONE      = 3'd0,
    ACT_HOLD      = 3'd1,
    ACT_ENTER_PPD = 3'd2,
    ACT_ENTER_SR  = 3'd3,
    ACT_ENTER_APD = 3'd4,
    ACT_EXIT_PD   = 3'd5,
    ACT_EXIT_SR   = 3'd6,
    ACT_ILLEGAL   = 3'd7
  } action_t;

  typedef struct packed {
    logic startRelock;
  } ctrlStrobe_t;

endpackage

// File: rtl/cke_datapath.sv
module cke_datapath
  import cke_tracker_pkg::*;
#(
  parameter int RELOCK_CYCLES = 200
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ckeIn,
  input  ctrlStrobe_t strobe,
  output logic        ckePrev,
  output logic        relockBusy
);

  localparam int CW = $clog2(RELOCK_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(RELOCK_CYCLES);

  logic [CW-1:0] edgeCount;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ckePrev   <= 1'b0;
      edgeCount <= LIMIT;
    end else begin
      ckePrev <= ckeIn;
      if (strobe.startRelock)
        edgeCount <= CW'(1);
      else if (edgeCount < LIMIT)
        edgeCount <= edgeCount + 1'b1;
    end
  end

  assign relockBusy = (edgeCount < LIMIT);

  // R10: every exit restarts the window
  p_restart_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.startRelock |=> (edgeCount == CW'(1)));

  // R9: an idle window stays idle without a new exit
  p_window_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!relockBusy && !strobe.startRelock) |=> !relockBusy);

endmodule

// File: rtl/cke_ctrl.sv
module cke_ctrl
  import cke_tracker_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ckeIn,
  input  cmd_t        cmdIn,
  input  logic        anyBankOpen,
  input  logic        ckePrev,
  input  logic        relockBusy,
  output pwrState_t   stateQ,
  output action_t     actionQ,
  output logic        illegalQ,
  output logic        readOk,
  output ctrlStrobe_t strobe
);

  pwrState_t nextState;
  action_t   nextAct;
  logic      isNop;
  logic      bothLow;
  logic      riseEdge;
  logic      fallEdge;
  logic      bothHigh;
  pwrState_t bankState;

  assign isNop     = (cmdIn == CMD_NOP);
  assign bothLow   = !ckePrev && !ckeIn;
  assign riseEdge  = !ckePrev && ckeIn;
  assign fallEdge  = ckePrev && !ckeIn;
  assign bothHigh  = ckePrev && ckeIn;
  assign bankState = anyBankOpen ? PS_ACTIVE : PS_IDLE;

  always_comb begin
    nextState          = stateQ;
    nextAct            = ACT_ILLEGAL;
    strobe.startRelock = 1'b0;
    case (stateQ)
      PS_SELF_REF: begin
        if (bothLow) begin
          nextAct = ACT_HOLD;
        end else if (riseEdge && isNop) begin
          nextState          = PS_IDLE;
          nextAct            = ACT_EXIT_SR;
          strobe.startRelock = 1'b1;
        end
      end
      PS_PRE_PD, PS_ACT_PD: begin
        if (bothLow) begin
          nextAct = ACT_HOLD;
        end else if (riseEdge && isNop) begin
          nextState = (stateQ == PS_PRE_PD) ? PS_IDLE : PS_ACTIVE;
          nextAct   = ACT_EXIT_PD;
        end
      end
      default: begin
        if (bothHigh) begin
          if (!(cmdIn == CMD_READ && relockBusy)) begin
            nextState = bankState;
            nextAct   = ACT_NONE;
          end
        end else if (fallEdge) begin
          if (!anyBankOpen && isNop) begin
            nextState = PS_PRE_PD;
            nextAct   = ACT_ENTER_PPD;
          end else if (!anyBankOpen && cmdIn == CMD_AREF) begin
            nextState = PS_SELF_REF;
            nextAct   = ACT_ENTER_SR;
          end else if (anyBankOpen && isNop) begin
            nextState = PS_ACT_PD;
            nextAct   = ACT_ENTER_APD;
          end
        end else if (riseEdge && isNop) begin
          nextState = bankState;
          nextAct   = ACT_NONE;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stateQ   <= PS_IDLE;
      actionQ  <= ACT_NONE;
      illegalQ <= 1'b0;
    end else begin
      stateQ   <= nextState;
      actionQ  <= nextAct;
      illegalQ <= (nextAct == ACT_ILLEGAL);
    end
  end

  assign readOk = (stateQ == PS_IDLE || stateQ == PS_ACTIVE) && !relockBusy;

  // R2: self refresh is held while the enable stays low
  p_sr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ == PS_SELF_REF && bothLow) |=> (stateQ == PS_SELF_REF && actionQ == ACT_HOLD));

  // R3: a clean exit lands in idle
  p_sr_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ == PS_SELF_REF && riseEdge && isNop) |=> (stateQ == PS_IDLE && actionQ == ACT_EXIT_SR));

  // R4: active power-down returns to bank active
  p_apd_return_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ == PS_ACT_PD && riseEdge && isNop) |=> (stateQ == PS_ACTIVE));

  // R9: a read inside the relock window is refused
  p_read_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((stateQ == PS_IDLE || stateQ == PS_ACTIVE) && bothHigh && cmdIn == CMD_READ && relockBusy)
      |=> (illegalQ && $stable(stateQ)));

  // R11: an illegal edge never moves the state
  p_illegal_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    illegalQ |-> (stateQ == $past(stateQ)));

endmodule

// File: rtl/cke_power_tracker.sv
module cke_power_tracker
  import cke_tracker_pkg::*;
#(
  parameter int RELOCK_CYCLES = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ckeIn,
  input  logic [1:0] cmdIn,
  input  logic       anyBankOpen,
  output logic [2:0] powerState,
  output logic [2:0] actionCode,
  output logic       illegalSeq,
  output logic       readOk
);

  ctrlStrobe_t strobe;
  logic        ckePrev;
  logic        relockBusy;
  pwrState_t   stateQ;
  action_t     actionQ;

  cke_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .ckeIn       (ckeIn),
    .cmdIn       (cmd_t'(cmdIn)),
    .anyBankOpen (anyBankOpen),
    .ckePrev     (ckePrev),
    .relockBusy  (relockBusy),
    .stateQ      (stateQ),
    .actionQ     (actionQ),
    .illegalQ    (illegalSeq),
    .readOk      (readOk),
    .strobe      (strobe)
  );

  cke_datapath #(.RELOCK_CYCLES(RELOCK_CYCLES)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .ckeIn      (ckeIn),
    .strobe     (strobe),
    .ckePrev    (ckePrev),
    .relockBusy (relockBusy)
  );

  assign powerState = stateQ;
  assign actionCode = actionQ;

endmodule

// File: tb/cke_power_tracker_bench.sv
`timescale 1ns/1ps
module cke_power_tracker_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ckeIn = 1'b0;
  logic [1:0] cmdIn = 2'd0;
  logic       anyBankOpen = 1'b0;
  logic [2:0] powerState;
  logic [2:0] actionCode;
  logic       illegalSeq;
  logic       readOk;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  cke_power_tracker #(.RELOCK_CYCLES(200)) u_cke_power_tracker (
    .clk(clk), .rst_n(rst_n), .ckeIn(ckeIn), .cmdIn(cmdIn),
    .anyBankOpen(anyBankOpen), .powerState(powerState),
    .actionCode(actionCode), .illegalSeq(illegalSeq), .readOk(readOk)
  );

  // {cke, cmd, bank, state, action, illegal, readOk}
  localparam int NV = 22;
  localparam logic [11:0] VEC [0:NV-1] = '{
    {1'b1, 2'd0, 1'b0, 3'd0, 3'd0, 1'b0, 1'b1},  // R8 bring-up
    {1'b1, 2'd0, 1'b1, 3'd1, 3'd0, 1'b0, 1'b1},  // R8 follows bank
    {1'b0, 2'd0, 1'b1, 3'd3, 3'd4, 1'b0, 1'b0},  // R7
    {1'b0, 2'd2, 1'b1, 3'd3, 3'd1, 1'b0, 1'b0},  // R4 hold
    {1'b1, 2'd3, 1'b1, 3'd3, 3'd7, 1'b1, 1'b0},  // R4 bad exit
    {1'b1, 2'd0, 1'b1, 3'd3, 3'd7, 1'b1, 1'b0},  // R11 prev high in PD
    {1'b0, 2'd0, 1'b1, 3'd3, 3'd7, 1'b1, 1'b0},  // R11 prev high in PD
    {1'b1, 2'd0, 1'b1, 3'd1, 3'd5, 1'b0, 1'b1},  // R4 exit to active
    {1'b1, 2'd0, 1'b0, 3'd0, 3'd0, 1'b0, 1'b1},  // R8
    {1'b0, 2'd0, 1'b0, 3'd2, 3'd2, 1'b0, 1'b0},  // R5
    {1'b0, 2'd0, 1'b0, 3'd2, 3'd1, 1'b0, 1'b0},  // R4 hold
    {1'b1, 2'd0, 1'b0, 3'd0, 3'd5, 1'b0, 1'b1},  // R4 exit to idle
    {1'b0, 2'd2, 1'b0, 3'd0, 3'd7, 1'b1, 1'b1},  // R11 read on fall
    {1'b0, 2'd0, 1'b0, 3'd0, 3'd7, 1'b1, 1'b1},  // R11 low-low normal
    {1'b1, 2'd0, 1'b0, 3'd0, 3'd0, 1'b0, 1'b1},  // R8 bring-up
    {1'b0, 2'd1, 1'b1, 3'd0, 3'd7, 1'b1, 1'b1},  // R11 refresh, bank open
    {1'b1, 2'd0, 1'b0, 3'd0, 3'd0, 1'b0, 1'b1},  // R8
    {1'b0, 2'd1, 1'b0, 3'd4, 3'd3, 1'b0, 1'b0},  // R6
    {1'b0, 2'd3, 1'b0, 3'd4, 3'd1, 1'b0, 1'b0},  // R2
    {1'b1, 2'd2, 1'b0, 3'd4, 3'd7, 1'b1, 1'b0},  // R3 bad exit
    {1'b0, 2'd0, 1'b0, 3'd4, 3'd7, 1'b1, 1'b0},  // R11 prev high in SR
    {1'b1, 2'd0, 1'b0, 3'd0, 3'd6, 1'b0, 1'b0}   // R3 exit
  };

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic step(input logic c, input logic [1:0] cm, input logic b);
    ckeIn = c; cmdIn = cm; anyBankOpen = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 2'd0, 1'b0);
  endtask

  initial begin
    #1500000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 state", powerState, 0);
    chk("R1 action", actionCode, 0);
    chk("R1 illegal", illegalSeq, 0);
    chk("R1 readOk", readOk, 1);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      step(VEC[v][11], VEC[v][10:9], VEC[v][8]);
      chk($sformatf("vec%0d state", v), powerState, int'(VEC[v][7:5]));
      chk($sformatf("vec%0d action", v), actionCode, int'(VEC[v][4:2]));
      chk($sformatf("vec%0d illegal", v), illegalSeq, int'(VEC[v][1]));
      chk($sformatf("vec%0d readOk", v), readOk, int'(VEC[v][0]));
    end

    // R9: read on edge 1 after exit is refused
    step(1'b1, 2'd2, 1'b0);
    chk("R9 early read illegal", illegalSeq, 1);
    chk("R9 early read state", powerState, 0);
    nops(49);                       // edges 2..50
    step(1'b0, 2'd1, 1'b0);         // edge 51: enter self refresh
    chk("R6 enter during window", actionCode, 3);
    step(1'b0, 2'd0, 1'b0);         // hold
    step(1'b1, 2'd0, 1'b0);         // second exit, new edge 0
    chk("R3 second exit", actionCode, 6);
    nops(149);                      // edges 1..149
    step(1'b1, 2'd2, 1'b0);         // edge 150
    chk("R10 window restarted", illegalSeq, 1);
    nops(48);                       // edges 151..198
    chk("R9 readOk low at 198", readOk, 0);
    nops(1);                        // edge 199
    chk("R9 readOk high at 199", readOk, 1);
    step(1'b1, 2'd2, 1'b0);         // edge 200
    chk("R9 read accepted action", actionCode, 0);
    chk("R9 read accepted illegal", illegalSeq, 0);

    // R1: reset from a low-power state
    step(1'b0, 2'd0, 1'b1);
    chk("R7 enter before reset", powerState, 3);
    rst_n = 1'b0;
    step(1'b0, 2'd0, 1'b0);
    chk("R1 reset state", powerState, 0);
    chk("R1 reset readOk", readOk, 1);
    rst_n = 1'b1;
    step(1'b0, 2'd0, 1'b0);         // previous sample reset low: low-low is illegal
    chk("R1 prev low after reset", illegalSeq, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule